// File: doc/BRIEF.md
# Packed SIMD Integer Compare and Add Unit

This block executes the integer compare, bit-test, add and subtract members of a vector instruction class in which both sources and the destination share one element size. It receives a 32-bit instruction word together with two 128-bit source vectors. From packed fields in the word it finds the lane width, the operation and whether the full vector or only its low half is used. It then works on every lane in parallel. A comparison lane returns a mask: all ones when the condition holds and all zeros when it does not. The add and subtract lanes wrap around inside the lane.

The same instruction class also has saturating, halving, shift, min/max, absolute-difference and multiply forms. This unit does not compute them. It classifies each such word: an encoding that the class does not allocate raises an illegal flag, and an allocated form that this unit does not implement raises an unsupported flag. The result, both flags and an output strobe come out of a single register stage one clock after the input strobe. A dispatcher can then retire the result or raise the right exception.

Top module: `simd3_int_unit`

## Requirements
- R1: A word presented with `in_valid` high at a rising edge produces `out_valid` high for exactly one cycle after that edge. `out_valid` is low in a cycle that follows an edge with `in_valid` low, and the result and flags then hold their last values.
- R2: Word bits [23:22] select the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Every lane works on its own, with no carry or borrow crossing a lane boundary.
- R3: Opcode bits [15:11] = 0x06 is a greater-than compare. It is signed when bit 29 is 0 and unsigned when bit 29 is 1. A true lane is all ones and a false lane is all zeros.
- R4: Opcode 0x07 is a greater-or-equal compare. Its signedness is selected by bit 29 in the same way as R3, and it returns the same mask encoding.
- R5: Opcode 0x10 adds the lanes when bit 29 is 0. When bit 29 is 1 it subtracts, first source minus second source. Both wrap modulo 2^width.
- R6: Opcode 0x11 with bit 29 = 1 is an equality compare. With bit 29 = 0 it is a bit-test, which is true when the AND of the two lanes is nonzero. Both return masks.
- R7: With bit 30 = 0, only the low 64 bits are processed and result bits [127:64] are zero. With bit 30 = 1, all 128 bits are processed.
- R8: Lane width 64 with bit 30 = 0 is illegal for opcodes 0x06, 0x07, 0x10, 0x11, 0x01, 0x05 and 0x08–0x0B. Otherwise opcodes 0x01, 0x05 and 0x08–0x0B are unsupported.
- R9: Opcodes 0x00, 0x02, 0x04, 0x0C–0x0F and 0x12 are illegal with lane width 64 and unsupported with any other width.
- R10: Opcode 0x13 is illegal with lane width 64, and also when bit 29 = 1 with a width other than 8; otherwise it is unsupported. Opcode 0x16 is illegal with width 8 or 64 and unsupported with width 16 or 32.
- R11: Every other opcode value (0x03, 0x14, 0x15, 0x17–0x1F) is illegal.
- R12: At most one flag is set in any output. The result is zero whenever either flag is set.
- R13: A synchronous active-low reset clears `out_valid`, both flags and the result. A word presented during reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe; the word and sources are taken at this edge |
| in_instr | input | 32 | Instruction word |
| in_src_a | input | 128 | First source vector |
| in_src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Result strobe, one clock after the input strobe |
| out_result | output | 128 | Lane-wise result |
| out_illegal | output | 1 | Encoding is unallocated |
| out_unsupported | output | 1 | Encoding is allocated but not implemented here |

## Verification
The hardest case to reach from the ports is a signed compare in which a lane's sign bit disagrees with its magnitude order, for example 0x80 against 0x7F. Such a lane must give opposite answers in the signed and unsigned forms, at every width. The stimulus builds operands from a repeated byte pattern, so every width gets a lane in which the sign bit alone decides the outcome. The same operand pair is then sent through both signedness forms, at each width and at both vector lengths. Random words mixing all opcode groups, lane widths and lengths then cover the decode corners, back to back, with no idle cycles between them.

// File: rtl/simd3_pkg.sv
// Shared definitions for the packed SIMD integer unit.
// Holds the field positions of the instruction word, the opcode values
// the unit decodes, and the decoded-control struct that the decoder
// passes to the datapath.
package simd3_pkg;

    localparam int INSTR_W   = 32;
    localparam int OPC_W     = 5;
    localparam int SIZE_W    = 2;
    localparam int POS_Q     = 30;
    localparam int POS_U     = 29;
    localparam int SIZE_LO   = 22;
    localparam int OPC_LO    = 11;
    localparam int N_WIDTHS  = 4;
    localparam int MIN_LANE  = 8;

    // Opcode values with behaviour in this unit
    localparam logic [OPC_W-1:0] OPC_GREATER    = 5'h06;
    localparam logic [OPC_W-1:0] OPC_GREATER_EQ = 5'h07;
    localparam logic [OPC_W-1:0] OPC_ADD_SUB    = 5'h10;
    localparam logic [OPC_W-1:0] OPC_TEST_EQ    = 5'h11;
    localparam logic [OPC_W-1:0] OPC_MULT       = 5'h13;
    localparam logic [OPC_W-1:0] OPC_DBL_MULH   = 5'h16;

    localparam logic [SIZE_W-1:0] SIZE_64 = 2'd3;
    localparam logic [SIZE_W-1:0] SIZE_8  = 2'd0;

    typedef enum logic [1:0] {
        KIND_GT    = 2'd0,
        KIND_GE    = 2'd1,
        KIND_ARITH = 2'd2,
        KIND_BITEQ = 2'd3
    } lane_kind_e;

    typedef struct packed {
        logic              full_width;
        logic              alt;
        logic [SIZE_W-1:0] esize;
        lane_kind_e        kind;
        logic              illegal;
        logic              unsupported;
    } dec_t;

endpackage

// File: rtl/simd3_decode.sv
// Instruction classifier for the packed SIMD integer unit.
// Turns the length, variant, size and opcode fields into a lane kind and
// two exclusive flags. Assumes the fields are already taken out of the
// word; it is purely combinational.
module simd3_decode
    import simd3_pkg::*;
(
    input  logic              q_full,
    input  logic              u_alt,
    input  logic [SIZE_W-1:0] size,
    input  logic [OPC_W-1:0]  opc,
    output dec_t              dec
);

    logic narrow64;
    logic wide64;

    // Size combinations that several opcode groups reject
    always_comb begin
        wide64   = (size == SIZE_64);
        narrow64 = wide64 && !q_full;
    end

    // Classify the opcode into a lane kind or an illegal/unsupported verdict
    always_comb begin
        dec             = '0;
        dec.full_width  = q_full;
        dec.alt         = u_alt;
        dec.esize       = size;
        dec.kind        = KIND_GT;
        case (opc)
            OPC_GREATER: begin
                dec.kind    = KIND_GT;
                dec.illegal = narrow64;
            end
            OPC_GREATER_EQ: begin
                dec.kind    = KIND_GE;
                dec.illegal = narrow64;
            end
            OPC_ADD_SUB: begin
                dec.kind    = KIND_ARITH;
                dec.illegal = narrow64;
            end
            OPC_TEST_EQ: begin
                dec.kind    = KIND_BITEQ;
                dec.illegal = narrow64;
            end
            5'h01, 5'h05, 5'h08, 5'h09, 5'h0A, 5'h0B: begin
                dec.illegal     = narrow64;
                dec.unsupported = !narrow64;
            end
            5'h00, 5'h02, 5'h04, 5'h0C, 5'h0D, 5'h0E, 5'h0F, 5'h12: begin
                dec.illegal     = wide64;
                dec.unsupported = !wide64;
            end
            OPC_MULT: begin
                dec.illegal     = wide64 || (u_alt && size != SIZE_8);
                dec.unsupported = !(wide64 || (u_alt && size != SIZE_8));
            end
            OPC_DBL_MULH: begin
                dec.illegal     = wide64 || (size == SIZE_8);
                dec.unsupported = !(wide64 || (size == SIZE_8));
            end
            default: begin
                dec.illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/simd3_lane.sv
// One lane of the packed SIMD integer datapath.
// Computes the compare, test, add or subtract result for a lane of LW
// bits. Compare-type kinds return an all-ones or all-zeros mask. Assumes
// the kind and variant bit are already decoded.
module simd3_lane
    import simd3_pkg::*;
#(
    parameter int LW = 8
) (
    input  lane_kind_e    kind,
    input  logic          alt,
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    output logic [LW-1:0] r
);

    logic gt_hit;
    logic ge_hit;
    logic be_hit;
    logic [LW-1:0] sum;
    logic [LW-1:0] diff;

    // Condition bits for the compare-type kinds
    always_comb begin
        gt_hit = alt ? (a > b)  : ($signed(a) > $signed(b));
        ge_hit = alt ? (a >= b) : ($signed(a) >= $signed(b));
        be_hit = alt ? (a == b) : (|(a & b));
    end

    // Wrapping arithmetic inside the lane
    always_comb begin
        sum  = a + b;
        diff = a - b;
    end

    // Select the lane result by kind
    always_comb begin
        case (kind)
            KIND_GT:    r = {LW{gt_hit}};
            KIND_GE:    r = {LW{ge_hit}};
            KIND_ARITH: r = alt ? diff : sum;
            default:    r = {LW{be_hit}};
        endcase
    end

endmodule

// File: rtl/simd3_width_slice.sv
// Full-vector datapath for one fixed lane width.
// Replicates the lane VEC_W/LW times over the source vectors. Assumes
// LW divides VEC_W.
module simd3_width_slice
    import simd3_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int LW    = 8
) (
    input  lane_kind_e       kind,
    input  logic             alt,
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    output logic [VEC_W-1:0] r
);

    localparam int LANES = VEC_W / LW;

    // One lane instance per element position
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        simd3_lane #(.LW(LW)) u_lane (
            .kind (kind),
            .alt  (alt),
            .a    (a[g*LW +: LW]),
            .b    (b[g*LW +: LW]),
            .r    (r[g*LW +: LW])
        );
    end

endmodule

// File: rtl/simd3_int_unit.sv
// Top of the packed SIMD integer compare/add unit.
// Takes a word and two source vectors on in_valid, computes every lane
// width in parallel, picks the width named by the size field, clears the
// upper half for the half-length form and registers the result with the
// flags. Assumes a synchronous active-low reset; the latency is one clock.
module simd3_int_unit
    import simd3_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    input  logic [VEC_W-1:0]   in_src_a,
    input  logic [VEC_W-1:0]   in_src_b,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_result,
    output logic               out_illegal,
    output logic               out_unsupported
);

    localparam int HALF_W = VEC_W / 2;

    dec_t             dec;
    logic [VEC_W-1:0] by_width [N_WIDTHS];
    logic [VEC_W-1:0] picked;
    logic [VEC_W-1:0] next_result;
    logic             unused_instr;

    // Register indices and fixed class bits do not affect this unit
    assign unused_instr = ^{in_instr[31], in_instr[28:24], in_instr[21:16], in_instr[10:0]};

    simd3_decode u_decode (
        .q_full (in_instr[POS_Q]),
        .u_alt  (in_instr[POS_U]),
        .size   (in_instr[SIZE_LO +: SIZE_W]),
        .opc    (in_instr[OPC_LO +: OPC_W]),
        .dec    (dec)
    );

    // One datapath per lane width: 8, 16, 32 and 64 bits
    for (genvar s = 0; s < N_WIDTHS; s++) begin : g_width
        simd3_width_slice #(
            .VEC_W (VEC_W),
            .LW    (MIN_LANE << s)
        ) u_slice (
            .kind (dec.kind),
            .alt  (dec.alt),
            .a    (in_src_a),
            .b    (in_src_b),
            .r    (by_width[s])
        );
    end

    // Choose the width, clear the upper half, and zero the result on any flag
    always_comb begin
        picked = by_width[dec.esize];
        if (!dec.full_width) begin
            picked[VEC_W-1:HALF_W] = '0;
        end
        next_result = (dec.illegal || dec.unsupported) ? '0 : picked;
    end

    // Output register stage, loaded only when a word is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid       <= 1'b0;
            out_illegal     <= 1'b0;
            out_unsupported <= 1'b0;
            out_result      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_illegal     <= dec.illegal;
                out_unsupported <= dec.unsupported;
                out_result      <= next_result;
            end
        end
    end

endmodule

// File: rtl/simd3_int_unit_chk.sv
// Property checker for the packed SIMD integer unit, bound to the top.
// Observes the ports only. Assumes the synchronous active-low reset.
module simd3_int_unit_chk
    import simd3_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [INSTR_W-1:0] in_instr,
    input logic               out_valid,
    input logic [VEC_W-1:0]   out_result,
    input logic               out_illegal,
    input logic               out_unsupported
);

    localparam int HALF_W = VEC_W / 2;

    logic [OPC_W-1:0]  c_opc;
    logic [SIZE_W-1:0] c_size;
    logic              c_q;
    logic              c_narrow_grp;
    logic              c_spare_opc;

    // Independent views of the word for the decode properties
    always_comb begin
        c_opc  = in_instr[15:11];
        c_size = in_instr[23:22];
        c_q    = in_instr[30];
        c_narrow_grp = (c_opc == 5'h06) || (c_opc == 5'h07) || (c_opc == 5'h10)
                    || (c_opc == 5'h11) || (c_opc == 5'h01) || (c_opc == 5'h05)
                    || (c_opc >= 5'h08 && c_opc <= 5'h0B);
        c_spare_opc  = (c_opc == 5'h03) || (c_opc == 5'h14) || (c_opc == 5'h15)
                    || (c_opc >= 5'h17);
    end

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_illegal) && $stable(out_unsupported)));

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !c_q) |=> (out_result[VEC_W-1:HALF_W] == '0));

    p_narrow64_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !c_q && c_size == 2'd3 && c_narrow_grp) |=> out_illegal);

    p_dbl_mulh_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_opc == 5'h16 && (c_size == 2'd0 || c_size == 2'd3)) |=> out_illegal);

    p_spare_opc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_spare_opc) |=> (out_illegal && !out_unsupported));

    p_flag_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_illegal && out_unsupported));

    p_flag_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_illegal || out_unsupported)) |-> (out_result == '0));

endmodule

bind simd3_int_unit simd3_int_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_instr        (in_instr),
    .out_valid       (out_valid),
    .out_result      (out_result),
    .out_illegal     (out_illegal),
    .out_unsupported (out_unsupported)
);

// File: tb/tb_simd3_int_unit.sv
`timescale 1ns/1ps
module tb_simd3_int_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_instr = '0;
    logic [127:0] in_src_a = '0;
    logic [127:0] in_src_b = '0;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_illegal;
    logic         out_unsupported;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [129:0] exp_q [$];
    string        tag_q [$];
    logic [129:0] last_exp = '0;

    always #10 clk = ~clk;

    simd3_int_unit dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .in_valid        (in_valid),
        .in_instr        (in_instr),
        .in_src_a        (in_src_a),
        .in_src_b        (in_src_b),
        .out_valid       (out_valid),
        .out_result      (out_result),
        .out_illegal     (out_illegal),
        .out_unsupported (out_unsupported)
    );

    // Build a word: q bit 30, u bit 29, size 23:22, opcode 15:11
    function automatic logic [31:0] mk(input bit q, input bit u, input logic [1:0] sz, input logic [4:0] op);
        return {1'b0, q, u, 5'b01110, sz, 1'b1, 5'd2, op, 1'b1, 5'd1, 5'd0};
    endfunction

    // Reference model: {illegal, unsupported, result}
    function automatic logic [129:0] model(input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b);
        bit q, u, ill, uns, t;
        logic [1:0] sz;
        logic [4:0] op;
        int lw, nl;
        logic [63:0] m, ea, eb, er;
        logic signed [63:0] sa, sb;
        logic [127:0] res;
        q = ins[30]; u = ins[29]; sz = ins[23:22]; op = ins[15:11];
        ill = 0; uns = 0; res = '0;
        case (op)
            5'h06, 5'h07, 5'h10, 5'h11: ill = (sz == 3) && !q;
            5'h01, 5'h05, 5'h08, 5'h09, 5'h0A, 5'h0B: begin
                ill = (sz == 3) && !q; uns = !ill;
            end
            5'h00, 5'h02, 5'h04, 5'h0C, 5'h0D, 5'h0E, 5'h0F, 5'h12: begin
                ill = (sz == 3); uns = !ill;
            end
            5'h13: begin ill = (sz == 3) || (u && sz != 0); uns = !ill; end
            5'h16: begin ill = (sz == 0) || (sz == 3); uns = !ill; end
            default: ill = 1;
        endcase
        if (!ill && !uns) begin
            lw = 8 << sz;
            nl = (q ? 128 : 64) / lw;
            m  = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
            for (int i = 0; i < nl; i++) begin
                ea = 64'(a >> (i * lw)) & m;
                eb = 64'(b >> (i * lw)) & m;
                sa = $signed(ea << (64 - lw));
                sb = $signed(eb << (64 - lw));
                t  = 0;
                case (op)
                    5'h06: t = u ? (ea > eb) : (sa > sb);
                    5'h07: t = u ? (ea >= eb) : (sa >= sb);
                    5'h11: t = u ? (ea == eb) : ((ea & eb) != 0);
                    default: t = 0;
                endcase
                if (op == 5'h10) er = (u ? (ea - eb) : (ea + eb)) & m;
                else             er = t ? m : 64'd0;
                res = res | ({64'd0, er} << (i * lw));
            end
        end
        return {ill, uns, res};
    endfunction

    // Driver: present one word for one cycle and queue its expected outcome
    task automatic send(input string tag, input logic [31:0] ins, input logic [127:0] a, input logic [127:0] b);
        in_valid = 1'b1;
        in_instr = ins;
        in_src_a = a;
        in_src_b = b;
        last_exp = model(ins, a, b);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input bit ok, input logic [129:0] act, input logic [129:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual ill=%0b uns=%0b res=%h expected ill=%0b uns=%0b res=%h",
                     tag, act[129], act[128], act[127:0], exp[129], exp[128], exp[127:0]);
        end
    endtask

    // Monitor: compare each result against the head of the queue
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected out_valid", 1'b0, {out_illegal, out_unsupported, out_result}, '0);
            end else begin
                logic [129:0] e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(tg, {out_illegal, out_unsupported, out_result} == e,
                      {out_illegal, out_unsupported, out_result}, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check("watchdog", 1'b0, '0, '0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam logic [127:0] PAT_A = {16{8'h80}} ^ 128'h0000_0000_0000_0000_0000_0000_0000_0080;
    localparam logic [127:0] PAT_B = {16{8'h7F}};

    initial begin
        logic [4:0] ops [12];
        ops = '{5'h06, 5'h07, 5'h10, 5'h11, 5'h01, 5'h0C, 5'h13, 5'h16, 5'h03, 5'h12, 5'h10, 5'h11};
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 reset state", out_valid == 0 && out_illegal == 0 && out_unsupported == 0 && out_result == 0,
              {out_illegal, out_unsupported, out_result}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", out_valid == 0, {out_illegal, out_unsupported, out_result}, '0);

        // R3/R4/R2: sign-versus-magnitude lanes at every width, both forms
        for (int sz = 0; sz < 4; sz++) begin
            for (int u = 0; u < 2; u++) begin
                send("R3 gt sign lanes", mk(1, u[0], sz[1:0], 5'h06), PAT_A, PAT_B);
                send("R3 gt reversed",   mk(1, u[0], sz[1:0], 5'h06), PAT_B, PAT_A);
                send("R4 ge equal",      mk(1, u[0], sz[1:0], 5'h07), PAT_A, PAT_A);
                send("R4 ge sign lanes", mk(1, u[0], sz[1:0], 5'h07), PAT_B, PAT_A);
                send("R7 gt half",       mk(0, u[0], 2'(sz == 3 ? 2 : sz), 5'h06), PAT_A, PAT_B);
            end
        end
        // R5: add and subtract with wrap, R2 no carry across lanes
        for (int sz = 0; sz < 4; sz++) begin
            send("R5 add wrap", mk(1, 0, sz[1:0], 5'h10), {16{8'hFF}}, {8{16'h0001}});
            send("R5 sub wrap", mk(1, 1, sz[1:0], 5'h10), 128'd0, {4{32'h0000_0001}});
            send("R2 add lanes", mk(1, 0, sz[1:0], 5'h10), 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'h8888_7777_6666_5555_4444_3333_2222_1111);
        end
        // R6: bit-test and equality
        send("R6 test zero and", mk(1, 0, 2'd0, 5'h11), {8{16'h0F00}}, {8{16'h00F0}});
        send("R6 test hit",      mk(1, 0, 2'd1, 5'h11), {8{16'h0180}}, {8{16'h0100}});
        send("R6 equal mix",     mk(1, 1, 2'd2, 5'h11), {32'h1, 32'h2, 32'h3, 32'h4}, {32'h1, 32'h9, 32'h3, 32'h8});
        send("R6 equal 64",      mk(1, 1, 2'd3, 5'h11), {64'hAB, 64'hCD}, {64'hAB, 64'hCE});
        // R7: half-length add clears the top
        send("R7 half add", mk(0, 0, 2'd2, 5'h10), {128{1'b1}}, {128{1'b1}});
        // R8: narrow 64-bit rejections and unsupported neighbours
        send("R8 gt narrow64",  mk(0, 0, 2'd3, 5'h06), PAT_A, PAT_B);
        send("R8 add narrow64", mk(0, 1, 2'd3, 5'h10), PAT_A, PAT_B);
        send("R8 op01 narrow64", mk(0, 0, 2'd3, 5'h01), PAT_A, PAT_B);
        send("R8 op0B full64",  mk(1, 0, 2'd3, 5'h0B), PAT_A, PAT_B);
        send("R8 op08 width8",  mk(0, 1, 2'd0, 5'h08), PAT_A, PAT_B);
        // R9
        send("R9 op0C size3", mk(1, 0, 2'd3, 5'h0C), PAT_A, PAT_B);
        send("R9 op12 size2", mk(1, 1, 2'd2, 5'h12), PAT_A, PAT_B);
        send("R9 op00 size0", mk(0, 0, 2'd0, 5'h00), PAT_A, PAT_B);
        // R10
        send("R10 op13 u1 size1", mk(1, 1, 2'd1, 5'h13), PAT_A, PAT_B);
        send("R10 op13 u1 size0", mk(1, 1, 2'd0, 5'h13), PAT_A, PAT_B);
        send("R10 op13 u0 size2", mk(1, 0, 2'd2, 5'h13), PAT_A, PAT_B);
        send("R10 op16 size0",    mk(1, 0, 2'd0, 5'h16), PAT_A, PAT_B);
        send("R10 op16 size1",    mk(1, 0, 2'd1, 5'h16), PAT_A, PAT_B);
        // R11
        send("R11 op03", mk(1, 0, 2'd0, 5'h03), PAT_A, PAT_B);
        send("R11 op14", mk(1, 1, 2'd2, 5'h14), PAT_A, PAT_B);
        send("R11 op1F", mk(0, 0, 2'd1, 5'h1F), PAT_A, PAT_B);

        // R1: result holds across idle cycles
        send("R1 hold source", mk(1, 0, 2'd1, 5'h10), PAT_A, PAT_B);
        idle(2);
        check("R1 hold", out_valid == 0 && {out_illegal, out_unsupported, out_result} == last_exp,
              {out_illegal, out_unsupported, out_result}, last_exp);

        // R12: random mix, back to back
        for (int n = 0; n < 400; n++) begin
            logic [127:0] ra, rb;
            logic [31:0]  w;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = ($urandom % 4 == 0) ? ra : {$urandom, $urandom, $urandom, $urandom};
            if ($urandom % 3 == 0) rb[31:0] = ra[31:0];
            w = mk($urandom % 2 == 1, $urandom % 2 == 1, 2'($urandom % 4), ops[$urandom % 12]);
            send("R12 random mix", w, ra, rb);
        end
        idle(3);

        // R13: word presented during reset is discarded
        rst_n = 1'b0;
        send("R13 discard", mk(1, 0, 2'd0, 5'h10), PAT_A, PAT_B);
        void'(exp_q.pop_back());
        void'(tag_q.pop_back());
        check("R13 reset clears", out_valid == 0 && out_illegal == 0 && out_unsupported == 0 && out_result == 0,
              {out_illegal, out_unsupported, out_result}, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);
        check("R13 nothing after reset", out_valid == 0 && out_result == 0,
              {out_illegal, out_unsupported, out_result}, '0);
        check("R1 queue drained", exp_q.size() == 0, 130'(exp_q.size()), '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule